// File: doc/BRIEF.md
# Matched filter complex multiplier

This block sits between a forward transform and its inverse in a frequency-domain pulse compressor. Every spectrum bin that leaves the forward transform arrives as a signed real/imaginary pair together with its bin number. The block multiplies the pair by the matched-filter coefficient held for that bin and hands the complex product to the inverse-transform path.

Coefficients live in an internal read-only table with one entry per bin. The table contents are computed from a fixed integer rule at elaboration. The datapath keeps full precision until the very end. Each of the four partial products is widened by one bit before the real difference and the imaginary sum are formed. Only the most significant output bits of that widened result are kept, so nothing can wrap.

The pipeline takes one bin per clock with no stall. The result appears exactly two clocks after its input, so a memory write strobe further down can be produced by delaying the input strobe by two cycles.

Top module: `mf_cmul`

## Requirements
- R1: A synchronous reset drives out_vld low and out_re and out_im to zero. They stay at those values until the first valid product reaches the output.
- R2: out_vld at the clock edge after edge N+1 equals the value in_vld had at edge N. The latency is exactly two clocks, with no other delay.
- R3: For data (ar, ai) and coefficient (br, bi), all 16-bit two's complement, out_re is the 33-bit value ar·br − ai·bi arithmetically shifted right by 17, which is bits 32 down to 17. It is correct for every input, including −32768 in every operand.
- R4: out_im is the 33-bit value ar·bi + ai·br, taken as bits 32 down to 17 in the same way as R3.
- R5: The coefficient is chosen by the in_bin value presented in the same cycle as the sample. For bin k, br is the low 16 bits of k·613 − 32768 and bi is the low 16 bits of 32767 − k·1381, both read as signed.
- R6: Samples presented on consecutive clocks produce results on consecutive clocks, in order, with none dropped.
- R7: A cycle with in_vld low has no effect on any later result. While out_vld is low, out_re and out_im keep the last product value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample valid |
| in_bin | input | AW (10) | Bin index selecting the coefficient |
| in_re | input | DW (16) | Sample real part, signed |
| in_im | input | DW (16) | Sample imaginary part, signed |
| out_vld | output | 1 | Product valid, two clocks after in_vld |
| out_re | output | OW (16) | Product real part, signed |
| out_im | output | OW (16) | Product imaginary part, signed |

## Verification
The bench builds the block with its default widths: 16-bit data, 16-bit coefficients, 16-bit outputs and a 10-bit bin index. With these widths a sweep of all 1024 table entries fits in a short run. Bin 0 holds −32768 and +32767, so feeding full-scale −32768 data there drives the widened sum to its largest magnitude. That case shows whether the extra bit and the top-bit selection avoid wrapping. Bursts of back-to-back samples, gaps carrying junk data and a reset while samples are in flight test the fixed two-cycle alignment and the hold behaviour.

// File: rtl/mf_cmul_pkg.sv
package mf_cmul_pkg;

    // Coefficient generation rule: value(k) = k * MUL + OFF, low bits kept
    localparam int COEF_RE_MUL = 613;
    localparam int COEF_RE_OFF = -32768;
    localparam int COEF_IM_MUL = -1381;
    localparam int COEF_IM_OFF = 32767;

    function automatic int coef_val(input int k, input int mul, input int off);
        return k * mul + off;
    endfunction

endpackage

// File: rtl/mf_coef_rom.sv
module mf_coef_rom #(
    parameter int AW = 10,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [AW-1:0]        addr,
    output logic signed [CW-1:0] c_re,
    output logic signed [CW-1:0] c_im
);
    import mf_cmul_pkg::*;

    localparam int DEPTH = 2 ** AW;

    typedef struct packed {
        logic signed [CW-1:0] re;
        logic signed [CW-1:0] im;
    } coef_t;

    coef_t tbl [DEPTH];

    // Table contents are computed per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign tbl[g].re = CW'(coef_val(g, COEF_RE_MUL, COEF_RE_OFF));
        assign tbl[g].im = CW'(coef_val(g, COEF_IM_MUL, COEF_IM_OFF));
    end

    coef_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (en) begin
            rd_d = tbl[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign c_re = rd_q.re;
    assign c_im = rd_q.im;

endmodule

// File: rtl/mf_cmul_math.sv
module mf_cmul_math #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int OW = 16
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [CW-1:0] b_re,
    input  logic signed [CW-1:0] b_im,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);
    localparam int PW = DW + CW;   // one partial product
    localparam int SW = PW + 1;    // widened sum, cannot wrap

    function automatic logic signed [OW-1:0] keep_top(input logic signed [SW-1:0] s);
        return s[SW-1 -: OW];
    endfunction

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [SW-1:0] s_re, s_im;

    assign p_rr = PW'(a_re) * PW'(b_re);
    assign p_ii = PW'(a_im) * PW'(b_im);
    assign p_ri = PW'(a_re) * PW'(b_im);
    assign p_ir = PW'(a_im) * PW'(b_re);

    assign s_re = {p_rr[PW-1], p_rr} - {p_ii[PW-1], p_ii};
    assign s_im = {p_ri[PW-1], p_ri} + {p_ir[PW-1], p_ir};

    assign y_re = keep_top(s_re);
    assign y_im = keep_top(s_im);

endmodule

// File: rtl/mf_cmul.sv
module mf_cmul #(
    parameter int AW = 10,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [AW-1:0]        in_bin,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_vld,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } s1_t;

    typedef struct packed {
        logic                 vld;
        logic signed [OW-1:0] re;
        logic signed [OW-1:0] im;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic signed [CW-1:0] rom_re, rom_im;
    logic signed [OW-1:0] mul_re, mul_im;

    // Stage 1 coefficient register, addressed with the incoming bin
    mf_coef_rom #(.AW(AW), .CW(CW)) u_rom (
        .clk  (clk),
        .rst  (rst),
        .en   (in_vld),
        .addr (in_bin),
        .c_re (rom_re),
        .c_im (rom_im)
    );

    // Stage 2 arithmetic on registered sample and coefficient
    mf_cmul_math #(.DW(DW), .CW(CW), .OW(OW)) u_math (
        .a_re (st_q.s1.re),
        .a_im (st_q.s1.im),
        .b_re (rom_re),
        .b_im (rom_im),
        .y_re (mul_re),
        .y_im (mul_im)
    );

    always_comb begin
        st_d = st_q;
        st_d.s1.vld = in_vld;
        if (in_vld) begin
            st_d.s1.re = in_re;
            st_d.s1.im = in_im;
        end
        st_d.s2.vld = st_q.s1.vld;
        if (st_q.s1.vld) begin
            st_d.s2.re = mul_re;
            st_d.s2.im = mul_im;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.s2.vld;
    assign out_re  = st_q.s2.re;
    assign out_im  = st_q.s2.im;

endmodule

// File: rtl/mf_cmul_chk.sv
module mf_cmul_chk #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int OW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_vld,
    input logic signed [DW-1:0] in_re,
    input logic signed [DW-1:0] in_im,
    input logic signed [CW-1:0] coef_re,
    input logic signed [CW-1:0] coef_im,
    input logic                 out_vld,
    input logic signed [OW-1:0] out_re,
    input logic signed [OW-1:0] out_im
);
    localparam int SHIFT = DW + CW + 1 - OW;

    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    function automatic logic signed [OW-1:0] top_of(input longint s);
        longint t;
        t = s >>> SHIFT;
        return t[OW-1:0];
    endfunction

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_vld && out_re == '0 && out_im == '0));

    p_latency_two_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

    p_real_product_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && out_vld) |->
        (out_re == top_of(longint'($past(in_re, 2)) * longint'($past(coef_re, 1))
                        - longint'($past(in_im, 2)) * longint'($past(coef_im, 1)))));

    p_imag_product_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && out_vld) |->
        (out_im == top_of(longint'($past(in_re, 2)) * longint'($past(coef_im, 1))
                        + longint'($past(in_im, 2)) * longint'($past(coef_re, 1)))));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && !out_vld) |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind mf_cmul mf_cmul_chk #(.DW(DW), .CW(CW), .OW(OW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_re   (in_re),
    .in_im   (in_im),
    .coef_re (rom_re),
    .coef_im (rom_im),
    .out_vld (out_vld),
    .out_re  (out_re),
    .out_im  (out_im)
);

// File: tb/sim_mf_cmul.sv
module sim_mf_cmul;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int OW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_vld = 1'b0;
    logic [AW-1:0]        in_bin = '0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 out_vld;
    logic signed [OW-1:0] out_re, out_im;

    always #2 clk = ~clk;   // 250 MHz

    mf_cmul #(.AW(AW), .DW(DW), .CW(CW), .OW(OW)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_bin(in_bin),
        .in_re(in_re), .in_im(in_im),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string ph = "";
    logic [31:0] seed = 32'h1234_5678;

    // Reference model: inputs applied one and two steps ago, plus held output
    bit m1_v = 0, m2_v = 0;
    int m1_k, m1_r, m1_i, m2_k, m2_r, m2_i;
    int hold_re = 0, hold_im = 0;

    function automatic int sx16(input int v);
        int t;
        t = v & 32'hFFFF;
        if (t >= 32768) t = t - 65536;
        return t;
    endfunction

    // R5: coefficient rule
    function automatic int cbr(input int k);
        return sx16(k * 613 - 32768);
    endfunction
    function automatic int cbi(input int k);
        return sx16(32767 - k * 1381);
    endfunction

    function automatic int ref_re(input int ar, input int ai, input int k);
        longint s;
        s = longint'(ar) * cbr(k) - longint'(ai) * cbi(k);
        return int'(s >>> 17);
    endfunction
    function automatic int ref_im(input int ar, input int ai, input int k);
        longint s;
        s = longint'(ar) * cbi(k) + longint'(ai) * cbr(k);
        return int'(s >>> 17);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s act=%0d exp=%0d", req, ph, what, act, exp);
        end
    endtask

    task automatic compare();
        int er, ei;
        chk(out_vld == m2_v, "R2", "out_vld", int'(out_vld), int'(m2_v));
        if (m2_v) begin
            er = ref_re(m2_r, m2_i, m2_k);
            ei = ref_im(m2_r, m2_i, m2_k);
            chk(int'(out_re) == er, "R3 R5", "out_re", int'(out_re), er);
            chk(int'(out_im) == ei, "R4 R5", "out_im", int'(out_im), ei);
            hold_re = er;
            hold_im = ei;
        end else begin
            chk(int'(out_re) == hold_re, "R7", "held out_re", int'(out_re), hold_re);
            chk(int'(out_im) == hold_im, "R7", "held out_im", int'(out_im), hold_im);
        end
    endtask

    task automatic step(input bit v, input int k, input int r, input int i);
        @(negedge clk);
        compare();
        in_vld = v;
        in_bin = k[AW-1:0];
        in_re  = r[DW-1:0];
        in_im  = i[DW-1:0];
        m2_v = m1_v; m2_k = m1_k; m2_r = m1_r; m2_i = m1_i;
        m1_v = v;
        m1_k = k & ((1 << AW) - 1);
        m1_r = sx16(r);
        m1_i = sx16(i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m1_v = 0; m2_v = 0;
        hold_re = 0; hold_im = 0;
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[31:16]);
    endfunction

    initial begin
        // R1: reset state
        ph = "R1";
        do_reset();
        @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld after reset", int'(out_vld), 0);
        chk(out_re == '0, "R1", "out_re after reset", int'(out_re), 0);
        chk(out_im == '0, "R1", "out_im after reset", int'(out_im), 0);

        // R2: isolated pulse, latency exactly two
        ph = "R2";
        step(1, 5, 1000, -2000);
        repeat (4) step(0, 0, 0, 0);

        // R3 R4: full-scale operands, bin 0 holds -32768 / +32767
        ph = "R3 R4";
        step(1, 0, -32768, -32768);
        step(1, 0, 32767, -32768);
        step(1, 0, -32768, 32767);
        step(1, 0, 32767, 32767);
        step(1, 1023, -32768, -32768);
        step(1, 1, 0, 0);
        step(1, 512, -1, -1);
        repeat (3) step(0, 0, 0, 0);

        // R6: back-to-back random stream
        ph = "R6";
        for (int n = 0; n < 300; n++) step(1, rnd(), rnd(), rnd());

        // R7: gaps with junk on idle cycles
        ph = "R7";
        for (int n = 0; n < 200; n++) begin
            if (rnd() % 3 == 0) step(1, rnd(), rnd(), rnd());
            else step(0, rnd(), rnd(), rnd());
        end

        // R5: every table entry in order
        ph = "R5";
        for (int k = 0; k < (1 << AW); k++) step(1, k, 20000 - k * 37, k * 29 - 15000);
        repeat (3) step(0, 0, 0, 0);

        // R1: reset while samples are in flight
        ph = "R1 mid";
        step(1, 77, 12345, -23456);
        step(1, 78, -31000, 30000);
        do_reset();
        @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld mid reset", int'(out_vld), 0);
        chk(out_re == '0, "R1", "out_re mid reset", int'(out_re), 0);
        chk(out_im == '0, "R1", "out_im mid reset", int'(out_im), 0);
        ph = "post";
        for (int n = 0; n < 20; n++) step(1, rnd(), rnd(), rnd());
        repeat (3) step(0, 0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule